// File: doc/BRIEF.md
# Multi-Cycle Accumulator Instruction Executor

This block runs a stream of instructions against one signed accumulator, X, and counts cycles exactly. There are two instruction kinds. A no-operation takes one cycle. An add-immediate takes two cycles, and its signed operand is folded into X only when the second cycle ends. Instructions arrive one at a time on a valid/ready handshake. Each handshake carries a kind bit and a 16-bit signed immediate.

For every executed cycle the block raises a strobe for one clock. With the strobe it reports the 1-based cycle number and the value X held during that cycle. A built-in sampler watches for a fixed arithmetic series of cycle numbers: 20, then every 40 cycles after that, six samples in all. At each of these cycles it adds the product of the cycle number and X to a signed running total. When no instruction is offered and none is in flight, the block stalls and its cycle count stands still.

Top module: `acc_exec_unit`

## Requirements
- R1: A synchronous active-high reset loads X with 1 and clears the cycle count, the strength total and any instruction in flight. After reset, cycleValid is 0, cycleNum is 0, strengthSum is 0, xOut is 1 and instReady is 1.
- R2: An accepted instruction with instIsAdd = 0 executes in exactly one cycle and leaves X unchanged. instReady stays 1 for the next clock.
- R3: An accepted instruction with instIsAdd = 1 executes in exactly two consecutive cycles. instReady is 0 during its second cycle, and the next instruction can be accepted right after that cycle.
- R4: The X reported for a cycle is the value before any add completing at the end of that cycle. The add's operand first shows in the following cycle.
- R5: When instValid is 0 and no add is in flight, no cycle executes: cycleValid stays 0 and cycleNum holds.
- R6: Executed cycles are numbered 1, 2, 3 and so on with no gaps. cycleNum, xOut and strengthSum update on the same clock that cycleValid pulses.
- R7: In a cycle whose number is 20 + 40*k for k = 0 to 5, the product cycle number times X is added to strengthSum. In any other cycle strengthSum is unchanged.
- R8: X and strengthSum are two's-complement signed. Negative immediates lower X, and a negative X at a sample cycle lowers the total.
- R9: After the sixth sample, at cycle 220, no further cycle changes strengthSum. In particular, cycle 260 adds nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instValid | input | 1 | Instruction offered |
| instIsAdd | input | 1 | 1 = add-immediate, 0 = no-operation |
| instImm | input | 16 | Signed add operand |
| instReady | output | 1 | Instruction accepted when valid in this cycle |
| xOut | output | 16 | X during the reported cycle (signed) |
| cycleNum | output | 16 | 1-based number of the reported cycle |
| cycleValid | output | 1 | One-clock pulse per executed cycle |
| strengthSum | output | 32 | Accumulated signal strength (signed) |

## Verification
The bench goes after four corner cases. The first is the timing of an add's write-back. A design that updated X after the first cycle would report the new value one cycle early. The second is back-to-back acceptance across an add's second cycle. A design that kept ready high there would lose or repeat a cycle, and the numbering would skip or stall. The third is stall gaps: a design that counted idle clocks would shift every later sample cycle. The fourth is the sample series itself, including negative X at sample points and a run well past cycle 260. An unsigned product or an unbounded sampler would show up as a wrong total.

// File: rtl/acc_exec_pkg.sv
package acc_exec_pkg;

  // Per-clock control strobes handed from the sequencer to the datapath.
  typedef struct packed {
    logic tick;      // one execution cycle happens at this edge
    logic latchImm;  // capture the operand of an accepted add
    logic applyAdd;  // second add cycle: fold operand into X
  } exec_strobe_t;

endpackage

// File: rtl/acc_exec_ctrl.sv
module acc_exec_ctrl
  import acc_exec_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         instValid,
  input  logic         instIsAdd,
  output logic         instReady,
  output exec_strobe_t st
);

  logic busy;     // add waiting for its second cycle
  logic accept;

  assign instReady = !busy;
  assign accept    = instValid && instReady;

  always_comb begin
    st.tick     = busy || accept;
    st.latchImm = accept && instIsAdd;
    st.applyAdd = busy;
  end

  always_ff @(posedge clk) begin
    if (rst) busy <= 1'b0;
    else     busy <= accept && instIsAdd;
  end

  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |-> !instReady);  // R3
  AST_ADD_SECOND_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (instValid && instReady && instIsAdd) |=> busy);  // R3
  AST_BUSY_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
    busy |=> !busy);  // R3
  AST_NOOP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (instValid && instReady && !instIsAdd) |=> instReady);  // R2

endmodule

// File: rtl/acc_exec_datapath.sv
module acc_exec_datapath
  import acc_exec_pkg::*;
#(
  parameter int X_W          = 16,
  parameter int SUM_W        = 32,
  parameter int CYC_W        = 16,
  parameter int FIRST_SAMPLE = 20,
  parameter int SAMPLE_STEP  = 40,
  parameter int SAMPLE_COUNT = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  exec_strobe_t            st,
  input  logic signed [X_W-1:0]   instImm,
  output logic signed [X_W-1:0]   xOut,
  output logic [CYC_W-1:0]        cycleNum,
  output logic                    cycleValid,
  output logic signed [SUM_W-1:0] strengthSum
);

  localparam int IDX_W = $clog2(SAMPLE_COUNT + 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(SAMPLE_COUNT);

  logic signed [X_W-1:0]   xReg;
  logic signed [X_W-1:0]   immReg;
  logic [CYC_W-1:0]        cycCnt;
  logic [CYC_W-1:0]        cycNext;
  logic [CYC_W-1:0]        nextSample;
  logic [IDX_W-1:0]        sampIdx;
  logic signed [SUM_W-1:0] sumReg;
  logic signed [SUM_W-1:0] cycSigned;
  logic signed [SUM_W-1:0] xWide;
  logic signed [SUM_W-1:0] strength;
  logic                    sampleHit;

  always_comb begin
    cycNext   = cycCnt + CYC_W'(1);
    cycSigned = $signed(SUM_W'(cycNext));
    xWide     = SUM_W'(xReg);
    strength  = cycSigned * xWide;
    sampleHit = st.tick && (sampIdx != IDX_LAST) && (cycNext == nextSample);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      xReg       <= X_W'(1);
      immReg     <= '0;
      cycCnt     <= '0;
      nextSample <= CYC_W'(FIRST_SAMPLE);
      sampIdx    <= '0;
      sumReg     <= '0;
      cycleValid <= 1'b0;
      cycleNum   <= '0;
      xOut       <= X_W'(1);
    end else begin
      cycleValid <= st.tick;
      if (st.latchImm) immReg <= instImm;
      if (st.tick) begin
        cycCnt   <= cycNext;
        cycleNum <= cycNext;
        xOut     <= xReg;
      end
      if (sampleHit) begin
        sumReg     <= sumReg + strength;
        nextSample <= nextSample + CYC_W'(SAMPLE_STEP);
        sampIdx    <= sampIdx + IDX_W'(1);
      end
      if (st.applyAdd) xReg <= xReg + immReg;
    end
  end

  assign strengthSum = sumReg;

  AST_RESET_X_ONE: assert property (@(posedge clk)
    rst |=> (xReg == X_W'(1)));  // R1
  AST_X_HOLD_NOOP: assert property (@(posedge clk) disable iff (rst)
    !st.applyAdd |=> $stable(xReg));  // R2
  AST_STALL_HOLDS_COUNT: assert property (@(posedge clk) disable iff (rst)
    !st.tick |=> $stable(cycCnt));  // R5
  AST_STALL_HOLDS_SUM: assert property (@(posedge clk) disable iff (rst)
    !st.tick |=> $stable(sumReg));  // R7
  AST_SAMPLE_LIMIT: assert property (@(posedge clk) disable iff (rst)
    sampIdx <= IDX_LAST);  // R9
  AST_ADD_NEEDS_OPERAND: assert property (@(posedge clk) disable iff (rst)
    st.applyAdd |-> $past(st.latchImm));  // R3

endmodule

// File: rtl/acc_exec_unit.sv
module acc_exec_unit
  import acc_exec_pkg::*;
#(
  parameter int X_W          = 16,
  parameter int SUM_W        = 32,
  parameter int CYC_W        = 16,
  parameter int FIRST_SAMPLE = 20,
  parameter int SAMPLE_STEP  = 40,
  parameter int SAMPLE_COUNT = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    instValid,
  input  logic                    instIsAdd,
  input  logic signed [X_W-1:0]   instImm,
  output logic                    instReady,
  output logic signed [X_W-1:0]   xOut,
  output logic [CYC_W-1:0]        cycleNum,
  output logic                    cycleValid,
  output logic signed [SUM_W-1:0] strengthSum
);

  exec_strobe_t st;

  acc_exec_ctrl i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .instValid (instValid),
    .instIsAdd (instIsAdd),
    .instReady (instReady),
    .st        (st)
  );

  acc_exec_datapath #(
    .X_W          (X_W),
    .SUM_W        (SUM_W),
    .CYC_W        (CYC_W),
    .FIRST_SAMPLE (FIRST_SAMPLE),
    .SAMPLE_STEP  (SAMPLE_STEP),
    .SAMPLE_COUNT (SAMPLE_COUNT)
  ) i_dp (
    .clk         (clk),
    .rst         (rst),
    .st          (st),
    .instImm     (instImm),
    .xOut        (xOut),
    .cycleNum    (cycleNum),
    .cycleValid  (cycleValid),
    .strengthSum (strengthSum)
  );

endmodule

// File: tb/test_acc_exec_unit.sv
module test_acc_exec_unit;

  logic clk = 1'b0;
  logic rst;
  logic instValid;
  logic instIsAdd;
  logic signed [15:0] instImm;
  logic instReady;
  logic signed [15:0] xOut;
  logic [15:0] cycleNum;
  logic cycleValid;
  logic signed [31:0] strengthSum;

  always #2.5 clk = ~clk;

  acc_exec_unit i_acc_exec_unit (
    .clk(clk), .rst(rst), .instValid(instValid), .instIsAdd(instIsAdd),
    .instImm(instImm), .instReady(instReady), .xOut(xOut),
    .cycleNum(cycleNum), .cycleValid(cycleValid), .strengthSum(strengthSum)
  );

  typedef struct {
    int cyc;
    int x;
    int sum;
  } exp_t;

  exp_t expQ[$];
  int checks = 0;
  int errors = 0;
  int mCyc = 0;
  int mX = 1;
  int mSum = 0;
  int mIdx = 0;
  int unsigned seed = 32'h1234_5678;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One modelled execution cycle: sample series 20 + 40*k, k < 6 (R7, R9).
  task automatic modelCycle();
    exp_t e;
    mCyc++;
    if (mIdx < 6 && mCyc == 20 + 40 * mIdx) begin
      mSum += mCyc * mX;
      mIdx++;
    end
    e.cyc = mCyc; e.x = mX; e.sum = mSum;
    expQ.push_back(e);
  endtask

  // Driver: called at a negedge; pushes expected cycles into the scoreboard.
  task automatic sendInst(input bit isAdd, input int imm);
    while (!instReady) @(negedge clk);
    instValid = 1'b1;
    instIsAdd = isAdd;
    instImm   = 16'(imm);
    modelCycle();
    if (isAdd) begin
      modelCycle();
      mX += imm;
    end
    @(negedge clk);
    instValid = 1'b0;
    if (isAdd) check(instReady == 1'b0, "R3 ready low in add second cycle", int'(instReady), 0);
    else       check(instReady == 1'b1, "R2 ready after no-op", int'(instReady), 1);
  endtask

  // Monitor: pops one expected item per executed cycle.
  always @(negedge clk) begin
    if (!rst && !done && cycleValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R5 unexpected executed cycle", int'(cycleNum), 0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check(int'(cycleNum) == e.cyc, "R6 cycle number", int'(cycleNum), e.cyc);
        check(int'(xOut) == e.x, "R4 reported X", int'(xOut), e.x);
        check(int'(strengthSum) == e.sum, "R7 strength total", int'(strengthSum), e.sum);
      end
    end
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int stallNum;
    rst = 1'b1; instValid = 1'b0; instIsAdd = 1'b0; instImm = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(cycleValid == 1'b0, "R1 cycleValid", int'(cycleValid), 0);
    check(cycleNum == 16'd0, "R1 cycleNum", int'(cycleNum), 0);
    check(strengthSum == 0, "R1 strengthSum", int'(strengthSum), 0);
    check(xOut == 16'sd1, "R1 xOut", int'(xOut), 1);
    check(instReady == 1'b1, "R1 instReady", int'(instReady), 1);

    // R2/R3/R4 directed: add then no-ops, back to back
    sendInst(1'b1, 5);
    sendInst(1'b0, 0);
    sendInst(1'b1, -40);   // R8: X goes negative
    sendInst(1'b1, 3);
    sendInst(1'b0, 0);
    repeat (2) @(negedge clk);

    // R5 stall: no valid, count must hold
    stallNum = int'(cycleNum);
    repeat (4) @(negedge clk);
    check(int'(cycleNum) == stallNum, "R5 cycleNum held in stall", int'(cycleNum), stallNum);
    check(cycleValid == 1'b0, "R5 no strobe in stall", int'(cycleValid), 0);

    // Bring cycle 20 near with negative X so the first sample is negative (R8)
    while (mCyc < 17) sendInst(1'b0, 0);
    sendInst(1'b1, -7);

    // Random mix, with an occasional stall, well past cycle 260 (R9)
    while (mCyc < 300) begin
      seed = seed * 1103515245 + 12345;
      if (((seed >> 8) & 7) == 0) begin
        instValid = 1'b0;
        repeat (3) @(negedge clk);
      end
      sendInst(((seed >> 16) & 1) == 1, int'((seed >> 17) % 41) - 20);
    end
    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R6 all cycles reported", expQ.size(), 0);
    check(mIdx == 6, "R9 six samples modelled", mIdx, 6);
    check(int'(strengthSum) == mSum, "R9 total after cycle 260", int'(strengthSum), mSum);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule